// File: doc/BRIEF.md
# Ethernet DMA Register and Pointer Unit

This block is the register front end of an Ethernet DMA engine. A simple load/store bus picks one 64-bit register by address. The block holds these registers:

- a control register with a soft reset bit;
- a DMA-control register, which enables each direction and selects the transmit ring size;
- the transmit-ring base address;
- a multicast filter mask;
- a station address.

Besides its registers, the block keeps the pointers that the software and the DMA engines share. For transmit, software writes the write pointer. The transmit engine moves the read pointer forward with a done strobe, and the pointer wraps at the ring size selected in DMA control.

For receive, software pushes buffer addresses through one window register into an internal 64-entry FIFO. The receive engine reads the head entry through the same window and pops it with a consume strobe. Both receive pointers are read-only on the bus.

Two level outputs tell the engines when there is work: `tx_pending` for transmit and `rx_ready` for receive. Interrupts, PHY management, backoff and the frame movement itself live outside the block.

Top module: `edma_regfile`

## Requirements
- R1: The register index is bus_addr[8:3]; bus_addr[2:0] have no effect. Load data appears on bus_rdata one cycle after the access and holds until the next load.
- R2: After rst_n, the control register (index 0) reads 1 and every pointer reads 0. Both tx_pending and rx_ready are 0.
- R3: While control bit 0 (soft reset) is 1, the following happens:
  - all four pointers are cleared and held at 0;
  - done and consume strobes are ignored;
  - window stores are ignored.
  Control reads back bit 0 only.
- R4: The DMA-control register (index 2) has these fields:
  - bit 0 enables transmit;
  - bit 1 enables receive;
  - bits 3:2 select the transmit ring size: 0 gives 128 entries, 1 gives 256, and 2 or 3 give 512.
- R5: A tx_done pulse while tx_pending is 1 advances the transmit read pointer (index 6) by one, wrapping to 0 after the last entry of the selected ring.
- R6: The transmit write pointer (index 7) is read/write. The stored value is the written data reduced modulo the current ring size.
- R7: Bus writes to the transmit read pointer (index 6), the receive read pointer (index 12) and the receive write pointer (index 13) are ignored.
- R8: A store to the receive window (index 32) writes the data at the FIFO write pointer, then advances the write pointer modulo 64.
- R9: A load from the receive window returns the FIFO entry at the receive read pointer. An rx_consume pulse while rx_ready is 1 advances that pointer modulo 64.
- R10: DMA control (2), ring base (21), multicast filter (22) and station address (23) are plain 64-bit read/write registers.
- R11: An access to any other index does the following:
  - bus_err pulses in the cycle after the access;
  - a load returns 0;
  - a store changes nothing.
- R12: The two work outputs are defined as follows:
  - tx_pending = soft reset clear AND transmit enabled AND the transmit pointers differ;
  - rx_ready = soft reset clear AND receive enabled AND the receive pointers differ.
  A strobe that arrives while its output is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for store, 0 for load |
| bus_addr | input | 9 | Byte address; index is bits 8:3 |
| bus_wdata | input | 64 | Store data |
| bus_rdata | output | 64 | Load data, registered |
| bus_err | output | 1 | Unimplemented-index pulse |
| tx_done | input | 1 | Transmit engine finished the entry at the read pointer |
| rx_consume | input | 1 | Receive engine used the head buffer address |
| tx_pending | output | 1 | Transmit work available |
| rx_ready | output | 1 | Receive buffer available |

## Verification
The results of an access arrive at different times:

- Load data and bus_err are registered, so they are due one edge after the cycle in which bus_sel is held.
- A store, done strobe or consume strobe changes its pointer at that same edge.
- tx_pending and rx_ready are decoded from registered state, so they follow in the same cycle as the pointer change.
- A soft reset takes one extra edge: the stored control bit first registers, and only then does it clear the pointers.

The bench drives every input at a falling edge and holds it for exactly one cycle. It samples at the next falling edge and reads pointers back over the bus only after the strobe cycle has ended, so each check lands after the edge that produced its result.

// File: rtl/edma_pkg.sv
package edma_pkg;
    localparam int IDX_W = 6;

    localparam logic [IDX_W-1:0] IDX_CTRL    = 6'd0;
    localparam logic [IDX_W-1:0] IDX_DMA     = 6'd2;
    localparam logic [IDX_W-1:0] IDX_TX_RPTR = 6'd6;
    localparam logic [IDX_W-1:0] IDX_TX_WPTR = 6'd7;
    localparam logic [IDX_W-1:0] IDX_RX_RPTR = 6'd12;
    localparam logic [IDX_W-1:0] IDX_RX_WPTR = 6'd13;
    localparam logic [IDX_W-1:0] IDX_RING    = 6'd21;
    localparam logic [IDX_W-1:0] IDX_MCAST   = 6'd22;
    localparam logic [IDX_W-1:0] IDX_STATION = 6'd23;
    localparam logic [IDX_W-1:0] IDX_RXWIN   = 6'd32;

    localparam int DMA_TXEN_BIT = 0;
    localparam int DMA_RXEN_BIT = 1;
    localparam int DMA_SIZE_LO  = 2;
endpackage

// File: rtl/edma_txring.sv
module edma_txring #(
    parameter int BASE_DEPTH = 128,
    parameter int PTR_W      = $clog2(BASE_DEPTH) + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             enable,
    input  logic [1:0]       size_sel,
    input  logic             wr_wptr,
    input  logic [PTR_W-1:0] wdata,
    input  logic             done,
    output logic [PTR_W-1:0] rptr,
    output logic [PTR_W-1:0] wptr,
    output logic             pending
);
    typedef struct packed {
        logic [PTR_W-1:0] rptr;
        logic [PTR_W-1:0] wptr;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic [PTR_W-1:0] mask;
    logic [1:0]       shift;

    always_comb begin
        shift = (size_sel > 2'd2) ? 2'd2 : size_sel;
        mask  = PTR_W'((BASE_DEPTH << shift) - 1);
    end

    assign pending = !hold && enable && (st_q.rptr != st_q.wptr);
    assign rptr    = st_q.rptr;
    assign wptr    = st_q.wptr;

    always_comb begin
        st_d = st_q;
        if (hold) begin
            st_d.rptr = '0;
            st_d.wptr = '0;
        end else begin
            if (wr_wptr)
                st_d.wptr = wdata & mask;
            if (done && pending)
                st_d.rptr = (st_q.rptr + PTR_W'(1)) & mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: soft reset leaves both pointers at zero
    assert_hold_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (rptr == '0 && wptr == '0));
    // R12: a done strobe with no pending work leaves the read pointer alone
    assert_idle_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pending && !hold) |=> $stable(rptr));
    // R5: an accepted done moves the read pointer off its old value
    assert_done_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pending) |=> (rptr != $past(rptr)));
endmodule

// File: rtl/edma_rxfifo.sv
module edma_rxfifo #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 64,
    parameter int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              enable,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [PTR_W-1:0]  rptr,
    output logic [PTR_W-1:0]  wptr,
    output logic              ready
);
    typedef struct packed {
        logic [PTR_W-1:0] rptr;
        logic [PTR_W-1:0] wptr;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic              do_push;

    assign ready   = !hold && enable && (st_q.rptr != st_q.wptr);
    assign do_push = push && !hold;
    assign head    = mem[st_q.rptr];
    assign rptr    = st_q.rptr;
    assign wptr    = st_q.wptr;

    always_comb begin
        st_d = st_q;
        if (hold) begin
            st_d.rptr = '0;
            st_d.wptr = '0;
        end else begin
            if (do_push)
                st_d.wptr = st_q.wptr + PTR_W'(1);
            if (pop && ready)
                st_d.rptr = st_q.rptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wptr] <= push_data;
    end

    // R8: every accepted push steps the write pointer by one
    assert_push_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        do_push |=> (wptr == $past(wptr) + PTR_W'(1)));
    // R12: a consume strobe with nothing ready is ignored
    assert_idle_pop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !hold) |=> $stable(rptr));
    // R9: an accepted consume steps the read pointer by one
    assert_pop_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && ready) |=> (rptr == $past(rptr) + PTR_W'(1)));
endmodule

// File: rtl/edma_regfile.sv
module edma_regfile
    import edma_pkg::*;
#(
    parameter int DATA_W        = 64,
    parameter int ADDR_W        = 9,
    parameter int TX_BASE_DEPTH = 128,
    parameter int RX_DEPTH      = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    input  logic              tx_done,
    input  logic              rx_consume,
    output logic              tx_pending,
    output logic              rx_ready
);
    localparam int TXP_W = $clog2(TX_BASE_DEPTH) + 2;
    localparam int RXP_W = $clog2(RX_DEPTH);

    typedef struct packed {
        logic              soft_rst;
        logic [DATA_W-1:0] dma;
        logic [DATA_W-1:0] ring;
        logic [DATA_W-1:0] mcast;
        logic [DATA_W-1:0] station;
        logic [DATA_W-1:0] rdata;
        logic              err;
    } regs_t;

    regs_t r_d, r_q;
    logic [IDX_W-1:0]  idx;
    logic              unused_lo;
    logic              st_hit, ld_hit;
    logic [TXP_W-1:0]  tx_rptr, tx_wptr;
    logic [RXP_W-1:0]  rx_rptr, rx_wptr;
    logic [DATA_W-1:0] rx_head;
    logic [DATA_W-1:0] rd_val;
    logic              rd_ok;

    assign idx       = bus_addr[ADDR_W-1:3];
    assign unused_lo = ^bus_addr[2:0];
    assign st_hit    = bus_sel && bus_wr;
    assign ld_hit    = bus_sel && !bus_wr;

    edma_txring #(.BASE_DEPTH(TX_BASE_DEPTH), .PTR_W(TXP_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (r_q.soft_rst),
        .enable   (r_q.dma[DMA_TXEN_BIT]),
        .size_sel (r_q.dma[DMA_SIZE_LO +: 2]),
        .wr_wptr  (st_hit && idx == IDX_TX_WPTR),
        .wdata    (bus_wdata[TXP_W-1:0]),
        .done     (tx_done),
        .rptr     (tx_rptr),
        .wptr     (tx_wptr),
        .pending  (tx_pending)
    );

    edma_rxfifo #(.DATA_W(DATA_W), .DEPTH(RX_DEPTH), .PTR_W(RXP_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (r_q.soft_rst),
        .enable    (r_q.dma[DMA_RXEN_BIT]),
        .push      (st_hit && idx == IDX_RXWIN),
        .push_data (bus_wdata),
        .pop       (rx_consume),
        .head      (rx_head),
        .rptr      (rx_rptr),
        .wptr      (rx_wptr),
        .ready     (rx_ready)
    );

    always_comb begin
        rd_ok  = 1'b1;
        rd_val = '0;
        case (idx)
            IDX_CTRL:    rd_val = DATA_W'(r_q.soft_rst);
            IDX_DMA:     rd_val = r_q.dma;
            IDX_TX_RPTR: rd_val = DATA_W'(tx_rptr);
            IDX_TX_WPTR: rd_val = DATA_W'(tx_wptr);
            IDX_RX_RPTR: rd_val = DATA_W'(rx_rptr);
            IDX_RX_WPTR: rd_val = DATA_W'(rx_wptr);
            IDX_RING:    rd_val = r_q.ring;
            IDX_MCAST:   rd_val = r_q.mcast;
            IDX_STATION: rd_val = r_q.station;
            IDX_RXWIN:   rd_val = rx_head;
            default:     rd_ok  = 1'b0;
        endcase
    end

    always_comb begin
        r_d     = r_q;
        r_d.err = bus_sel && !rd_ok;
        if (ld_hit)
            r_d.rdata = rd_ok ? rd_val : '0;
        if (st_hit) begin
            case (idx)
                IDX_CTRL:    r_d.soft_rst = bus_wdata[0];
                IDX_DMA:     r_d.dma      = bus_wdata;
                IDX_RING:    r_d.ring     = bus_wdata;
                IDX_MCAST:   r_d.mcast    = bus_wdata;
                IDX_STATION: r_d.station  = bus_wdata;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.soft_rst <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_rdata = r_q.rdata;
    assign bus_err   = r_q.err;

    // R11: an error pulse only follows an access
    assert_err_after_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_sel));
    // R1: load data holds while no load is in flight
    assert_rdata_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ld_hit) |-> $stable(bus_rdata));
    // R12: nothing is pending while soft reset is set
    assert_quiet_in_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.soft_rst |-> (!tx_pending && !rx_ready));
endmodule

// File: tb/edma_regfile_test.sv
module edma_regfile_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        bus_err;
    logic        tx_done = 1'b0, rx_consume = 1'b0;
    logic        tx_pending, rx_ready;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    edma_regfile uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .tx_done(tx_done), .rx_consume(rx_consume),
        .tx_pending(tx_pending), .rx_ready(rx_ready)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [63:0] d, input logic [2:0] lo = 3'd0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = {idx[5:0], lo}; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [63:0] d, output logic e,
                      input logic [2:0] lo = 3'd0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = {idx[5:0], lo};
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata; e = bus_err;
    endtask

    task automatic pulse_done();
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
    endtask

    task automatic pulse_consume();
        @(negedge clk); rx_consume = 1'b1;
        @(negedge clk); rx_consume = 1'b0;
    endtask

    task automatic soft_reset();
        wr(0, 64'd1);
        @(negedge clk);
        wr(0, 64'd0);
    endtask

    function automatic bit implemented(input int i);
        return i == 0 || i == 2 || i == 6 || i == 7 || i == 12 || i == 13 ||
               i == 21 || i == 22 || i == 23 || i == 32;
    endfunction

    function automatic logic [63:0] rxval(input int i);
        return 64'hC0DE_0000_0000_0000 | (64'(i) * 64'd3 + 64'd7);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] d;
        logic        e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: state after reset
        rd(0, d, e);  chk("R2 ctrl reset bit", d, 64'd1);
        rd(6, d, e);  chk("R2 tx rptr", d, 0);
        rd(7, d, e);  chk("R2 tx wptr", d, 0);
        rd(12, d, e); chk("R2 rx rptr", d, 0);
        rd(13, d, e); chk("R2 rx wptr", d, 0);
        chk("R2 tx_pending", 64'(tx_pending), 0);
        chk("R2 rx_ready", 64'(rx_ready), 0);

        // R3: while soft reset is set, tx wptr writes and window stores are held off
        wr(7, 64'd9); wr(32, 64'h55);
        rd(7, d, e);  chk("R3 tx wptr held", d, 0);
        rd(13, d, e); chk("R3 rx wptr held", d, 0);

        wr(0, 64'd0);
        rd(0, d, e); chk("R3 ctrl cleared", d, 0);

        // R10/R4: DMA control is a full 64-bit register
        wr(2, 64'hF0F0_1234_0000_0000);
        rd(2, d, e); chk("R10 dma readback", d, 64'hF0F0_1234_0000_0000);
        chk("R4 tx disabled", 64'(tx_pending), 0);

        // R1/R7/R10/R11: sweep every index (ring size 0 -> mask 127)
        wr(2, 64'd0);
        for (int i = 0; i < 64; i++) begin
            logic [63:0] pat;
            logic [63:0] exp;
            if (i == 0 || i == 2 || i == 32) continue;
            pat = {26'h2AB_CDEF, i[5:0], 32'h5A5A_0000 | 32'(i)};
            wr(i, pat);
            rd(i, d, e);
            if (!implemented(i)) begin
                exp = 0;
                chk("R11 unimplemented load zero", d, exp);
                chk("R11 err flag", 64'(e), 1);
            end else begin
                if (i == 7)
                    exp = pat & 64'd127;
                else if (i == 6 || i == 12 || i == 13)
                    exp = 0;
                else
                    exp = pat;
                chk((i == 6 || i == 12 || i == 13) ? "R7 read-only ignores write" :
                    (i == 7) ? "R6 tx wptr masked" : "R10 read/write register", d, exp);
                chk("R11 no err on implemented", 64'(e), 0);
            end
        end
        // R11: no error pulse when no access is made
        @(negedge clk);
        chk("R11 err idle", 64'(bus_err), 0);

        // R1: low address bits ignored
        wr(22, 64'h1111_2222_3333_4444, 3'd5);
        rd(22, d, e, 3'd3); chk("R1 low addr bits ignored", d, 64'h1111_2222_3333_4444);

        // R1: load data holds until the next load
        repeat (3) @(negedge clk);
        chk("R1 rdata held", bus_rdata, 64'h1111_2222_3333_4444);

        // R3: soft reset clears pointers set during the sweep
        soft_reset();
        rd(7, d, e); chk("R3 tx wptr cleared", d, 0);

        // R5/R6/R4: ring-size sweep with full wrap
        for (int s = 0; s < 4; s++) begin
            int lim;
            lim = 128 << ((s > 2) ? 2 : s);
            soft_reset();
            wr(2, 64'(s << 2) | 64'd1);
            wr(7, 64'(lim + 3));
            rd(7, d, e); chk("R6 wptr modulo ring size", d, 64'd3);
            wr(7, 64'd0);
            for (int k = 0; k < lim; k++) begin
                wr(7, 64'((k + 1) % lim));
                if (k % 97 == 0) chk("R12 tx_pending set", 64'(tx_pending), 1);
                pulse_done();
                if (k % 97 == 0 || k >= lim - 2) begin
                    rd(6, d, e);
                    chk("R5 tx rptr advance/wrap", d, 64'((k + 1) % lim));
                end
            end
            chk("R12 tx_pending clear when equal", 64'(tx_pending), 0);
            pulse_done();
            rd(6, d, e); chk("R12 done ignored when idle", d, 0);
        end

        // R12: transmit disabled blocks pending and done
        wr(2, 64'd0);
        wr(7, 64'd5);
        chk("R12 tx disabled no pending", 64'(tx_pending), 0);
        pulse_done();
        rd(6, d, e); chk("R12 done ignored when disabled", d, 0);

        // R8/R9: receive FIFO
        soft_reset();
        wr(2, 64'd2);
        for (int i = 0; i < 63; i++) wr(32, rxval(i));
        rd(13, d, e); chk("R8 rx wptr after 63 stores", d, 64'd63);
        chk("R12 rx_ready set", 64'(rx_ready), 1);
        for (int k = 0; k < 63; k++) begin
            rd(32, d, e); chk("R9 window load head", d, rxval(k));
            pulse_consume();
        end
        rd(12, d, e); chk("R9 rx rptr after drain", d, 64'd63);
        chk("R12 rx_ready clear when empty", 64'(rx_ready), 0);

        // R8/R9: wrap across 64
        for (int j = 0; j < 3; j++) wr(32, rxval(100 + j));
        rd(13, d, e); chk("R8 rx wptr wraps mod 64", d, 64'd2);
        for (int j = 0; j < 3; j++) begin
            rd(32, d, e); chk("R9 head across wrap", d, rxval(100 + j));
            pulse_consume();
        end
        rd(12, d, e); chk("R9 rx rptr wraps mod 64", d, 64'd2);
        pulse_consume();
        rd(12, d, e); chk("R12 consume ignored when empty", d, 64'd2);

        // R12: receive disabled
        wr(2, 64'd0);
        wr(32, rxval(200));
        chk("R12 rx disabled no ready", 64'(rx_ready), 0);
        pulse_consume();
        rd(12, d, e); chk("R12 consume ignored when disabled", d, 64'd2);

        // R3: soft reset during activity, strobes ignored while held
        wr(2, 64'd3);
        wr(7, 64'd4);
        wr(0, 64'd1);
        @(negedge clk);
        pulse_done(); pulse_consume();
        chk("R3 no pending in reset", 64'(tx_pending | rx_ready), 0);
        rd(6, d, e);  chk("R3 tx rptr zero", d, 0);
        rd(7, d, e);  chk("R3 tx wptr zero", d, 0);
        rd(12, d, e); chk("R3 rx rptr zero", d, 0);
        rd(13, d, e); chk("R3 rx wptr zero", d, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule